// File: doc/BRIEF.md
# I2C Slave Address Match and Receive Controller

This block is the receive side of an I2C target. It runs from a system clock that is much faster than the bus clock. Both bus lines pass through synchronizers. From the synchronized lines the block finds START, repeated START and STOP. It shifts in each byte MSB first and decides whether the byte is addressed to it. The block can accept either a 7-bit address or a 10-bit address. For each accepted byte it pulls SDA low during the ninth clock. Software reads received bytes from a single holding register.

The holding register has a full flag and a sticky overflow flag. If either flag is still set when a new byte arrives, the block withholds the acknowledge. The byte is then dropped, but the interrupt flag is still raised so that software learns about it. In 10-bit mode there is only one address register. After each address byte is accepted, the block holds SCL low and raises an update-address flag. The bus stays stalled until software writes the other half of the address into that register. Software clears the interrupt and overflow flags with strobes of their own.

Top module: `i2c_slave_rx`

## Requirements
- R1: While `enable` is low, the block drives neither line and does not respond. After enabling, bits clocked without a preceding START are ignored: no ACK is given and `irq` stays low.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP returns the block to idle and forgets any 10-bit address match.
- R3: In 7-bit mode, received bits [7:1] (MSB first) are compared with `addr` bits [7:1], and bit 0 is R/W (0 = write). On a mismatch there is no ACK and no `irq`, and the rest of the transfer is ignored until the next START or STOP.
- R4: An accepted byte is an address match or a data byte after a write match. It is copied to `rd_data` and sets `buf_full` at the eighth SCL falling edge. SDA is held low through the ninth clock, and `irq` is set at the ninth SCL falling edge.
- R5: If `buf_full` or `overflow` is already set when a byte that would be accepted completes, there is no ACK, `rd_data` is unchanged and `irq` is still set. The rest of the transfer is then ignored.
- R6: A byte withheld under R5 sets `overflow` only if `buf_full` was set. `overflow` stays set until an `ovf_clr` pulse. `rd_en` clears `buf_full` and nothing else.
- R7: In 10-bit mode, the first address byte must be 11110 followed by A9, A8 and R/W = 0. A9 and A8 are compared with `addr` bits [2:1].
- R8: In 10-bit mode, each accepted address byte sets `upd_addr`, and SCL is held low after the ninth falling edge. A write through `addr_wr` clears `upd_addr` and releases SCL.
- R9: The second 10-bit address byte is compared with all eight bits of `addr`. On a mismatch there is no ACK, no `upd_addr` and no stretch.
- R10: After a full 10-bit match, a repeated START needs only the first address byte to match, with either R/W value. This byte is acknowledged without setting `upd_addr` and without stretching.
- R11: `irq` stays set through a buffer read and is cleared only by `irq_clr`.
- R12: In 7-bit mode, a matched address with R/W = 1 is acknowledged. The bytes that follow are not received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable |
| ten_bit_mode | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (stretch) |
| sda_oe | output | 1 | Pull SDA low (ACK) |
| rd_en | input | 1 | Buffer read strobe, clears `buf_full` |
| rd_data | output | 8 | Receive buffer |
| addr_wr | input | 1 | Address register write strobe |
| addr_wdata | input | 8 | Address register write data |
| ovf_clr | input | 1 | Overflow clear strobe |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| buf_full | output | 1 | Buffer holds an unread byte |
| overflow | output | 1 | A byte was lost while the buffer was full |
| upd_addr | output | 1 | Host must rewrite the address register |
| irq | output | 1 | Per-byte interrupt flag |

## Verification
Addressing is tried with four kinds of first byte:
- an exact 7-bit write match;
- an address that differs in its last address bit, to show that bit [1] is compared;
- a matched read address;
- 10-bit headers with a wrong A9/A8 and with R/W = 1.

Each 10-bit transfer also pairs a correct header with a wrong low byte. Together these separate a full compare from a partial one, and a clean acknowledge from a flag-gated refusal.

Data bytes are sent in three states: with the buffer empty, with the buffer full, and with only the overflow flag set. Comparing the three shows that the acknowledge, the buffer load and the overflow flag depend on the flags each one should.

A repeated START is sent both before and after a STOP. This shows the short 10-bit path being granted and then revoked.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_LO,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic   hit;
        phase_e nxt;
        logic   want_upd;
        logic   full_ten;
    } match_t;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync
    import i2c_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_prev;
        logic                   sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (SYNC_STAGES > 1) begin
            s_d.scl_pipe = {s_q.scl_pipe[SYNC_STAGES-2:0], scl_i};
            s_d.sda_pipe = {s_q.sda_pipe[SYNC_STAGES-2:0], sda_i};
        end else begin
            s_d.scl_pipe = SYNC_STAGES'(scl_i);
            s_d.sda_pipe = SYNC_STAGES'(sda_i);
        end
        s_d.scl_prev = s_q.scl_pipe[LAST];
        s_d.sda_prev = s_q.sda_pipe[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{scl_pipe: '1, sda_pipe: '1, scl_prev: 1'b1, sda_prev: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    logic scl_now, sda_now, scl_held;
    assign scl_now  = s_q.scl_pipe[LAST];
    assign sda_now  = s_q.sda_pipe[LAST];
    assign scl_held = scl_now & s_q.scl_prev;

    assign ev.scl_rise = scl_now & ~s_q.scl_prev;
    assign ev.scl_fall = ~scl_now & s_q.scl_prev;
    assign ev.start    = scl_held & s_q.sda_prev & ~sda_now;
    assign ev.stop     = scl_held & ~s_q.sda_prev & sda_now;
    assign ev.sda      = sda_now;
endmodule

// File: rtl/i2c_rx_match.sv
module i2c_rx_match
    import i2c_rx_pkg::*;
(
    input  phase_e              phase,
    input  logic                ten_bit,
    input  logic                ten_held,
    input  logic [BYTE_W-1:0]   shreg,
    input  logic [BYTE_W-1:0]   addr,
    output match_t              res
);
    logic seven_ok, hdr_ok, is_read;

    assign seven_ok = (shreg[BYTE_W-1:1] == addr[BYTE_W-1:1]);
    assign hdr_ok   = (shreg[BYTE_W-1:3] == TEN_PREFIX) && (shreg[2:1] == addr[2:1]);
    assign is_read  = shreg[0];

    always_comb begin
        res = '{hit: 1'b0, nxt: PH_SKIP, want_upd: 1'b0, full_ten: 1'b0};
        unique case (phase)
            PH_ADDR: begin
                if (!ten_bit) begin
                    res.hit = seven_ok;
                    res.nxt = is_read ? PH_SKIP : PH_DATA;
                end else if (ten_held) begin
                    res.hit = hdr_ok;
                    res.nxt = is_read ? PH_SKIP : PH_DATA;
                end else begin
                    res.hit      = hdr_ok && !is_read;
                    res.nxt      = PH_ADDR_LO;
                    res.want_upd = 1'b1;
                end
            end
            PH_ADDR_LO: begin
                res.hit      = (shreg == addr);
                res.nxt      = PH_DATA;
                res.want_upd = 1'b1;
                res.full_ten = 1'b1;
            end
            PH_DATA: begin
                res.hit = 1'b1;
                res.nxt = PH_DATA;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ten_bit,
    input  bus_ev_t           ev,
    input  logic              rd_en,
    input  logic              addr_wr,
    input  logic [BYTE_W-1:0] addr_wdata,
    input  logic              ovf_clr,
    input  logic              irq_clr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              buf_full,
    output logic              overflow,
    output logic              upd_addr,
    output logic              irq,
    output logic              sda_pull,
    output logic              scl_pull
);
    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] rbuf;
        logic [BYTE_W-1:0] addr;
        logic              full;
        logic              ovf;
        logic              upd;
        logic              flag;
        logic              pend;
        logic              ack;
        logic              stretch;
        logic              ten_held;
    } ctrl_t;

    ctrl_t c_d, c_q;
    match_t m;

    i2c_rx_match u_match (
        .phase    (c_q.phase),
        .ten_bit  (ten_bit),
        .ten_held (c_q.ten_held),
        .shreg    (c_q.shreg),
        .addr     (c_q.addr),
        .res      (m)
    );

    always_comb begin
        c_d = c_q;
        if (addr_wr) begin
            c_d.addr    = addr_wdata;
            c_d.upd     = 1'b0;
            c_d.stretch = 1'b0;
        end
        if (rd_en)   c_d.full = 1'b0;
        if (ovf_clr) c_d.ovf  = 1'b0;
        if (irq_clr) c_d.flag = 1'b0;

        if (!enable || ev.stop) begin
            c_d.phase    = PH_IDLE;
            c_d.cnt      = '0;
            c_d.ack      = 1'b0;
            c_d.pend     = 1'b0;
            c_d.stretch  = 1'b0;
            c_d.ten_held = 1'b0;
        end else if (ev.start) begin
            c_d.phase   = PH_ADDR;
            c_d.cnt     = '0;
            c_d.ack     = 1'b0;
            c_d.pend    = 1'b0;
            c_d.stretch = 1'b0;
        end else if (c_q.phase != PH_IDLE) begin
            if (ev.scl_rise && c_q.cnt < CNT_LAST) begin
                c_d.shreg = {c_q.shreg[BYTE_W-2:0], ev.sda};
                c_d.cnt   = c_q.cnt + 1'b1;
            end else if (ev.scl_fall && c_q.cnt == CNT_LAST) begin
                c_d.cnt = CNT_ACK;
                if (c_q.phase != PH_SKIP) begin
                    if (!m.hit) begin
                        c_d.phase = PH_SKIP;
                    end else if (!c_q.full && !c_q.ovf) begin
                        c_d.pend  = 1'b1;
                        c_d.rbuf  = c_q.shreg;
                        c_d.full  = 1'b1;
                        c_d.ack   = 1'b1;
                        c_d.phase = m.nxt;
                        if (m.want_upd && ten_bit) c_d.upd      = 1'b1;
                        if (m.full_ten)            c_d.ten_held = 1'b1;
                    end else begin
                        c_d.pend  = 1'b1;
                        c_d.phase = PH_SKIP;
                        if (c_q.full) c_d.ovf = 1'b1;
                    end
                end
            end else if (ev.scl_fall && c_q.cnt == CNT_ACK) begin
                c_d.cnt     = '0;
                c_d.ack     = 1'b0;
                c_d.pend    = 1'b0;
                c_d.stretch = c_d.upd;
                if (c_q.pend) c_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_data  = c_q.rbuf;
    assign buf_full = c_q.full;
    assign overflow = c_q.ovf;
    assign upd_addr = c_q.upd;
    assign irq      = c_q.flag;
    assign sda_pull = c_q.ack;
    assign scl_pull = c_q.stretch;
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
    import i2c_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ten_bit_mode,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              addr_wr,
    input  logic [BYTE_W-1:0] addr_wdata,
    input  logic              ovf_clr,
    input  logic              irq_clr,
    output logic              buf_full,
    output logic              overflow,
    output logic              upd_addr,
    output logic              irq
);
    bus_ev_t ev;

    i2c_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_rx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .ten_bit    (ten_bit_mode),
        .ev         (ev),
        .rd_en      (rd_en),
        .addr_wr    (addr_wr),
        .addr_wdata (addr_wdata),
        .ovf_clr    (ovf_clr),
        .irq_clr    (irq_clr),
        .rd_data    (rd_data),
        .buf_full   (buf_full),
        .overflow   (overflow),
        .upd_addr   (upd_addr),
        .irq        (irq),
        .sda_pull   (sda_oe),
        .scl_pull   (scl_oe)
    );
endmodule

// File: rtl/i2c_slave_rx_checker.sv
module i2c_slave_rx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       sda_oe,
    input logic       scl_oe,
    input logic       upd_addr,
    input logic       buf_full,
    input logic       overflow,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       ovf_clr,
    input logic       irq,
    input logic       irq_clr
);
    p_quiet_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sda_oe && !scl_oe));

    p_ack_into_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (buf_full && !$past(buf_full) && !overflow));

    p_buf_only_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $rose(buf_full));

    p_no_overflow_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);

    p_read_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && rd_en) |=> !buf_full);

    p_stretch_needs_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> upd_addr);

    p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
endmodule

bind i2c_slave_rx i2c_slave_rx_checker u_chk (.*);

// File: tb/i2c_slave_rx_bench.sv
module i2c_slave_rx_bench;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       ten = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_oe, sda_oe;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       addr_wr = 1'b0;
    logic [7:0] addr_wdata = 8'h00;
    logic       ovf_clr = 1'b0;
    logic       irq_clr = 1'b0;
    logic       buf_full, overflow, upd_addr, irq;
    logic       scl_line, sda_line;
    int         n_chk = 0;
    int         n_bad = 0;
    int         cyc = 0;
    logic       ak;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    i2c_slave_rx u_i2c_slave_rx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ten_bit_mode(ten),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rd_en(rd_en), .rd_data(rd_data), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .ovf_clr(ovf_clr), .irq_clr(irq_clr), .buf_full(buf_full),
        .overflow(overflow), .upd_addr(upd_addr), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic scl_up();
        scl_m = 1'b1;
        while (scl_line !== 1'b1) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl_up(); waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl_up(); waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitq();
            scl_up(); waitq();
            scl_m = 1'b0; waitq();
        end
        sda_m = 1'b1; waitq();
        scl_up(); waitq();
        acked = ~sda_line;
        scl_m = 1'b0; waitq(); waitq();
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; @(negedge clk); s = 1'b0; @(negedge clk);
    endtask

    task automatic host_read(); pulse(rd_en); endtask
    task automatic host_irq_clr(); pulse(irq_clr); endtask
    task automatic host_ovf_clr(); pulse(ovf_clr); endtask
    task automatic host_addr(input logic [7:0] a);
        addr_wdata = a; pulse(addr_wr);
    endtask

    task automatic t_reset();
        chk("R4 reset buf_full", buf_full, 0);
        chk("R6 reset overflow", overflow, 0);
        chk("R11 reset irq", irq, 0);
        chk("R8 reset upd_addr", upd_addr, 0);
        chk("R1 reset scl_oe/sda_oe", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_ignore();
        bus_start(); send_byte(8'hB4, ak);
        chk("R1 no ack when disabled", ak, 0);
        chk("R1 no irq when disabled", irq, 0);
        bus_stop();
        enable = 1'b1; waitq();
        scl_m = 1'b0; waitq();
        send_byte(8'hB4, ak);
        chk("R1 no ack without START", ak, 0);
        chk("R1 no irq without START", irq, 0);
        bus_stop();
    endtask

    task automatic t_seven_write();
        bus_start(); send_byte(8'hB4, ak);
        chk("R4 address ack", ak, 1);
        chk("R4 address in buffer", rd_data, 8'hB4);
        chk("R4 buf_full set", buf_full, 1);
        chk("R4 irq set", irq, 1);
        host_read();
        chk("R6 read clears buf_full", buf_full, 0);
        chk("R11 irq survives read", irq, 1);
        host_irq_clr();
        chk("R11 irq_clr clears", irq, 0);
        send_byte(8'h3C, ak);
        chk("R4 data ack", ak, 1);
        chk("R4 data in buffer", rd_data, 8'h3C);
        chk("R4 data irq", irq, 1);
        host_read(); host_irq_clr();
        bus_stop();
    endtask

    task automatic t_mismatch();
        bus_start(); send_byte(8'hB6, ak);
        chk("R3 mismatch nack", ak, 0);
        chk("R3 mismatch no irq", irq, 0);
        chk("R3 mismatch no load", buf_full, 0);
        send_byte(8'h11, ak);
        chk("R3 following byte nack", ak, 0);
        chk("R3 buffer unchanged", rd_data, 8'h3C);
        bus_stop();
    endtask

    task automatic t_overflow();
        bus_start(); send_byte(8'hB4, ak);
        chk("R4 ack before overflow", ak, 1);
        host_irq_clr();
        send_byte(8'h77, ak);
        chk("R5 nack when full", ak, 0);
        chk("R5 irq when full", irq, 1);
        chk("R5 buffer kept", rd_data, 8'hB4);
        chk("R6 overflow set", overflow, 1);
        bus_stop();
        host_read(); host_irq_clr();
        chk("R6 read keeps overflow", overflow, 1);
        bus_start(); send_byte(8'hB4, ak);
        chk("R5 nack when overflow only", ak, 0);
        chk("R5 irq when overflow only", irq, 1);
        chk("R6 no load, buf_full low", buf_full, 0);
        chk("R6 overflow still set", overflow, 1);
        bus_stop();
        host_ovf_clr(); host_irq_clr();
        chk("R6 ovf_clr clears", overflow, 0);
    endtask

    task automatic t_seven_read();
        bus_start(); send_byte(8'hB5, ak);
        chk("R12 read address ack", ak, 1);
        chk("R12 read address loaded", rd_data, 8'hB5);
        host_read(); host_irq_clr();
        send_byte(8'h99, ak);
        chk("R12 following byte nack", ak, 0);
        chk("R12 buffer unchanged", rd_data, 8'hB5);
        chk("R12 no irq", irq, 0);
        bus_stop();
    endtask

    task automatic t_ten_full();
        ten = 1'b1; host_addr(8'hF4);
        bus_start(); send_byte(8'hF4, ak);
        chk("R7 header ack", ak, 1);
        chk("R8 upd_addr after header", upd_addr, 1);
        chk("R8 SCL held after header", scl_oe, 1);
        chk("R4 header irq", irq, 1);
        host_read(); host_irq_clr();
        host_addr(8'hC6);
        chk("R8 write clears upd_addr", upd_addr, 0);
        chk("R8 write releases SCL", scl_oe, 0);
        send_byte(8'hC6, ak);
        chk("R9 low byte ack", ak, 1);
        chk("R8 upd_addr after low byte", upd_addr, 1);
        chk("R8 SCL held after low byte", scl_oe, 1);
        host_read(); host_irq_clr();
        host_addr(8'hF4);
        chk("R8 release after restore", scl_oe, 0);
        send_byte(8'h42, ak);
        chk("R4 ten-bit data ack", ak, 1);
        chk("R4 ten-bit data value", rd_data, 8'h42);
        chk("R8 no upd on data", upd_addr, 0);
        host_read(); host_irq_clr();
        bus_start(); send_byte(8'hF5, ak);
        chk("R10 restart header ack", ak, 1);
        chk("R10 no upd_addr", upd_addr, 0);
        chk("R10 no stretch", scl_oe, 0);
        chk("R10 header loaded", rd_data, 8'hF5);
        host_read(); host_irq_clr();
        bus_stop();
    endtask

    task automatic t_ten_reject();
        bus_start(); send_byte(8'hF5, ak);
        chk("R2 STOP forgets 10-bit match", ak, 0);
        bus_stop();
        bus_start(); send_byte(8'hF6, ak);
        chk("R7 wrong A9/A8 nack", ak, 0);
        bus_stop();
        bus_start(); send_byte(8'hF4, ak);
        chk("R7 header ack again", ak, 1);
        host_read(); host_irq_clr();
        host_addr(8'hC6);
        send_byte(8'hC7, ak);
        chk("R9 wrong low byte nack", ak, 0);
        chk("R9 no upd_addr", upd_addr, 0);
        chk("R9 no stretch", scl_oe, 0);
        chk("R9 buffer unchanged", rd_data, 8'hF4);
        bus_stop();
        host_addr(8'hF4);
        ten = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        host_addr(8'hB4);
        t_reset();
        t_ignore();
        t_seven_write();
        t_mismatch();
        t_overflow();
        t_seven_read();
        t_ten_full();
        t_ten_reject();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule